// File: doc/BRIEF.md
# Shadow-Register Interrupt Unit

This block handles interrupts for a small 32-bit load/store core. It holds four 32-bit shadow registers, a 32-bit interrupt mask, an interrupt-enable flag and a pending-request latch. It decodes five custom instructions that share one major opcode, and it redirects the program counter into a fixed handler when an unmasked request is pending.

On entry, shadow register 0 receives the interrupted PC. Shadow register 1 receives every unmasked pending source as a single bitmask, so one handler pass may service several sources. The core passes in the instruction word, the first source operand, the current PC, a valid strobe and 32 request lines. It takes back:
- a destination-write value with its enable,
- a PC redirect with its target,
- a stall,
- an entry strobe,
- an illegal-encoding flag,
- a halted flag.

Some request lines are designated internal traps. If one of them fires while it is masked, or while interrupts are disabled, the unit halts permanently.

Top module: `irq_unit`

## Requirements
- R1: After reset the mask is all-ones, nothing is pending, interrupts are enabled and the unit is not halted. A mask-swap issued first therefore returns 0xFFFFFFFF.
- R2: Instructions use opcode bits[6:0]=0001011, funct3 bits[14:12]=000, rs2 bits[24:20]=0, and are selected by funct7 bits[31:25]. Read-shadow (funct7=0) sets rd_we and returns the shadow register chosen by bits[16:15] in the same cycle. Write-shadow (funct7=1) loads rs1_val into the register chosen by bits[8:7] at the clock edge.
- R3: Mask-swap (funct7=3) returns the old mask on rd_val with rd_we in the same cycle, and loads rs1_val as the new mask at the edge. A set mask bit disables that source.
- R4: When interrupts are enabled and (pending & ~mask) is nonzero, irq_enter and pc_redir are high and pc_target equals ENTRY_ADDR in that cycle. At the edge, shadow 0 takes cur_pc, shadow 1 takes the serviced bits, those bits leave pending, and interrupts become disabled, so no entry follows in the next cycle.
- R5: Several sources pending together are reported in one entry as one bitmask in shadow 1.
- R6: Return (funct7=2) redirects to shadow 0 in the same cycle and re-enables interrupts at the edge.
- R7: Wait (funct7=4) holds stall high with rd_we low while pending is zero. Once pending is nonzero, it drops stall and returns the pending bitmask with rd_we.
- R8: An opcode-0001011 word with unknown funct7, nonzero funct3 or nonzero rs2 raises illegal for that cycle, writes nothing, redirects nothing and changes no state.
- R9: A request on a line set in TRAP_MASK (default bits 0..2) while that line is masked or interrupts are disabled sets halted permanently. While halted, stall is high and no write, redirect or entry occurs.
- R10: A masked request stays latched in pending, and entry follows once its mask bit is cleared.
- R11: A word with any other opcode produces no write, redirect or illegal flag.
- R12: An entry takes precedence over an instruction presented in the same cycle: that instruction produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand value |
| cur_pc | input | 32 | PC of the presented instruction |
| irq_req | input | 32 | Interrupt request lines |
| rd_we | output | 1 | Destination write enable |
| rd_val | output | 32 | Destination write value |
| pc_redir | output | 1 | PC redirect |
| pc_target | output | 32 | Redirect target |
| stall | output | 1 | Hold the core |
| irq_enter | output | 1 | Handler entry this cycle |
| illegal | output | 1 | Unrecognized custom encoding |
| halted | output | 1 | Unit halted by a blocked trap |

## Verification
Entry and instruction execution compete in the same cycle, and this is the hardest situation to reach. With the reset mask of all-ones, a request only latches, so the bench sets up the mask first. It then raises several sources in one cycle, including one that stays masked. It presents a read-shadow instruction in the very cycle the latched requests make entry fire. This shows precedence over the instruction, the combined bitmask in shadow 1, and the masked source left pending; the wait instruction later returns that pending source.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int XLEN = 32;
    localparam int NQ   = 4;
    localparam int QW   = $clog2(NQ);
    localparam logic [6:0] OPC_CUSTOM = 7'b0001011;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GETQ,
        OP_SETQ,
        OP_RET,
        OP_MASK,
        OP_WAIT,
        OP_BAD
    } irq_op_e;

    typedef struct packed {
        logic [NQ-1:0][XLEN-1:0] q;
        logic [XLEN-1:0]         mask;
        logic [XLEN-1:0]         pending;
        logic                    en;
        logic                    halted;
    } irq_state_t;
endpackage

// File: rtl/irq_decode.sv
module irq_decode
    import irq_pkg::*;
(
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    output irq_op_e         op,
    output logic [QW-1:0]   qsel_rs,
    output logic [QW-1:0]   qsel_rd
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [4:0] f_rs2;
    logic [6:0] f7;

    always_comb begin
        opc     = instr[6:0];
        f3      = instr[14:12];
        f_rs2   = instr[24:20];
        f7      = instr[31:25];
        qsel_rs = instr[15 +: QW];
        qsel_rd = instr[7 +: QW];
        op      = OP_NONE;
        if (instr_valid && opc == OPC_CUSTOM) begin
            if (f3 != 3'd0 || f_rs2 != 5'd0) begin
                op = OP_BAD;
            end else begin
                unique case (f7)
                    7'd0:    op = OP_GETQ;
                    7'd1:    op = OP_SETQ;
                    7'd2:    op = OP_RET;
                    7'd3:    op = OP_MASK;
                    7'd4:    op = OP_WAIT;
                    default: op = OP_BAD;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_trap_check.sv
module irq_trap_check
    import irq_pkg::*;
#(
    parameter logic [XLEN-1:0] TRAP_MASK = 32'h0000_0007
) (
    input  logic [XLEN-1:0] irq_req,
    input  logic [XLEN-1:0] mask_q,
    input  logic            en_q,
    output logic            trap_hit
);
    logic [XLEN-1:0] blocked;

    always_comb begin
        blocked  = mask_q | {XLEN{~en_q}};
        trap_hit = |(irq_req & TRAP_MASK & blocked);
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  irq_op_e         op,
    input  logic [QW-1:0]   qsel_rs,
    input  logic [QW-1:0]   qsel_rd,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] irq_req,
    input  logic            trap_hit,
    output logic [XLEN-1:0] mask_q,
    output logic            en_q,
    output logic            rd_we,
    output logic [XLEN-1:0] rd_val,
    output logic            pc_redir,
    output logic [XLEN-1:0] pc_target,
    output logic            stall,
    output logic            irq_enter,
    output logic            illegal,
    output logic            halted
);
    irq_state_t s_d, s_q;
    logic [XLEN-1:0] svc;

    always_comb begin
        s_d       = s_q;
        rd_we     = 1'b0;
        rd_val    = '0;
        pc_redir  = 1'b0;
        pc_target = '0;
        stall     = 1'b0;
        irq_enter = 1'b0;
        illegal   = 1'b0;
        svc       = s_q.pending & ~s_q.mask;

        if (s_q.halted) begin
            stall = 1'b1;
        end else begin
            s_d.pending = s_q.pending | irq_req;
            if (trap_hit) begin
                s_d.halted = 1'b1;
            end
            if (s_q.en && (svc != '0)) begin
                irq_enter   = 1'b1;
                pc_redir    = 1'b1;
                pc_target   = ENTRY_ADDR;
                s_d.q[0]    = cur_pc;
                s_d.q[1]    = svc;
                s_d.pending = (s_q.pending & ~svc) | irq_req;
                s_d.en      = 1'b0;
            end else begin
                unique case (op)
                    OP_GETQ: begin
                        rd_we  = 1'b1;
                        rd_val = s_q.q[qsel_rs];
                    end
                    OP_SETQ: begin
                        s_d.q[qsel_rd] = rs1_val;
                    end
                    OP_RET: begin
                        pc_redir  = 1'b1;
                        pc_target = s_q.q[0];
                        s_d.en    = 1'b1;
                    end
                    OP_MASK: begin
                        rd_we    = 1'b1;
                        rd_val   = s_q.mask;
                        s_d.mask = rs1_val;
                    end
                    OP_WAIT: begin
                        if (s_q.pending == '0) begin
                            stall = 1'b1;
                        end else begin
                            rd_we  = 1'b1;
                            rd_val = s_q.pending;
                        end
                    end
                    OP_BAD: begin
                        illegal = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.q[0]    <= '0;
            s_q.q[1]    <= '0;
            s_q.mask    <= '1;
            s_q.pending <= '0;
            s_q.en      <= 1'b1;
            s_q.halted  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask_q = s_q.mask;
    assign en_q   = s_q.en;
    assign halted = s_q.halted;
endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_pkg::*;
#(
    parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0010,
    parameter logic [XLEN-1:0] TRAP_MASK  = 32'h0000_0007
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] irq_req,
    output logic            rd_we,
    output logic [XLEN-1:0] rd_val,
    output logic            pc_redir,
    output logic [XLEN-1:0] pc_target,
    output logic            stall,
    output logic            irq_enter,
    output logic            illegal,
    output logic            halted
);
    irq_op_e         op;
    logic [QW-1:0]   qsel_rs;
    logic [QW-1:0]   qsel_rd;
    logic [XLEN-1:0] mask_q;
    logic            en_q;
    logic            trap_hit;

    irq_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .op          (op),
        .qsel_rs     (qsel_rs),
        .qsel_rd     (qsel_rd)
    );

    irq_trap_check #(.TRAP_MASK(TRAP_MASK)) u_trap (
        .irq_req  (irq_req),
        .mask_q   (mask_q),
        .en_q     (en_q),
        .trap_hit (trap_hit)
    );

    irq_ctrl #(.ENTRY_ADDR(ENTRY_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .qsel_rs   (qsel_rs),
        .qsel_rd   (qsel_rd),
        .rs1_val   (rs1_val),
        .cur_pc    (cur_pc),
        .irq_req   (irq_req),
        .trap_hit  (trap_hit),
        .mask_q    (mask_q),
        .en_q      (en_q),
        .rd_we     (rd_we),
        .rd_val    (rd_val),
        .pc_redir  (pc_redir),
        .pc_target (pc_target),
        .stall     (stall),
        .irq_enter (irq_enter),
        .illegal   (illegal),
        .halted    (halted)
    );
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
    parameter logic [31:0] ENTRY_ADDR = 32'h0000_0010
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_we,
    input logic        pc_redir,
    input logic [31:0] pc_target,
    input logic        stall,
    input logic        irq_enter,
    input logic        illegal,
    input logic        halted
);
    a_r4_enter_target: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |-> (pc_redir && pc_target == ENTRY_ADDR));

    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> !irq_enter);

    a_r12_enter_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |-> !rd_we);

    a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rd_we && !pc_redir && !stall));

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r9_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (stall && !rd_we && !pc_redir && !irq_enter && !illegal));

    a_r7_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !rd_we);
endmodule

bind irq_unit irq_unit_chk #(.ENTRY_ADDR(ENTRY_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_we     (rd_we),
    .pc_redir  (pc_redir),
    .pc_target (pc_target),
    .stall     (stall),
    .irq_enter (irq_enter),
    .illegal   (illegal),
    .halted    (halted)
);

// File: tb/sim_irq_unit.sv
module sim_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = 32'h0000_0013;
    logic [31:0] rs1_val = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] irq_req = '0;
    logic        rd_we, pc_redir, stall, irq_enter, illegal, halted;
    logic [31:0] rd_val, pc_target;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_val(rs1_val), .cur_pc(cur_pc), .irq_req(irq_req),
        .rd_we(rd_we), .rd_val(rd_val), .pc_redir(pc_redir), .pc_target(pc_target),
        .stall(stall), .irq_enter(irq_enter), .illegal(illegal), .halted(halted)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs1f,
                                        input logic [2:0] f3, input logic [4:0] rdf,
                                        input logic [6:0] opc);
        return {f7, 5'd0, rs1f, f3, rdf, opc};
    endfunction

    function automatic logic [31:0] i_getq(input logic [1:0] qs);
        return enc(7'd0, {3'd0, qs}, 3'd0, 5'd5, 7'b0001011);
    endfunction
    function automatic logic [31:0] i_setq(input logic [1:0] qd);
        return enc(7'd1, 5'd6, 3'd0, {3'd0, qd}, 7'b0001011);
    endfunction
    localparam logic [31:0] I_RET  = {7'd2, 25'b0000000000000000000001011};
    localparam logic [31:0] I_MASK = {7'd3, 5'd0, 5'd6, 3'd0, 5'd5, 7'b0001011};
    localparam logic [31:0] I_WAIT = {7'd4, 5'd0, 5'd0, 3'd0, 5'd5, 7'b0001011};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [31:0] w, input logic [31:0] op1,
                         input logic [31:0] pc, input logic [31:0] req);
        @(negedge clk);
        instr_valid = v;
        instr       = w;
        rs1_val     = op1;
        cur_pc      = pc;
        irq_req     = req;
        #1;
    endtask

    task automatic idle();
        issue(1'b0, 32'h0000_0013, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 halted", {31'd0, halted}, 32'd0);
        chk("R1 stall", {31'd0, stall}, 32'd0);
        chk("R1 enter", {31'd0, irq_enter}, 32'd0);
        issue(1'b1, I_MASK, 32'hFFFF_FFFF, 32'h40, 32'h0);
        chk("R1 mask reset value", rd_val, 32'hFFFF_FFFF);
        chk("R1 mask read we", {31'd0, rd_we}, 32'd1);
    endtask

    task automatic t_shadow();
        issue(1'b1, i_setq(2'd2), 32'hA5A5_5A5A, 32'h44, 32'h0);
        chk("R2 setq no write", {31'd0, rd_we}, 32'd0);
        issue(1'b1, i_setq(2'd3), 32'h0000_1234, 32'h48, 32'h0);
        issue(1'b1, i_getq(2'd2), 32'h0, 32'h4C, 32'h0);
        chk("R2 getq q2", rd_val, 32'hA5A5_5A5A);
        chk("R2 getq we", {31'd0, rd_we}, 32'd1);
        issue(1'b1, i_getq(2'd3), 32'h0, 32'h50, 32'h0);
        chk("R2 getq q3", rd_val, 32'h0000_1234);
    endtask

    task automatic t_wait();
        issue(1'b1, I_WAIT, 32'h0, 32'h54, 32'h0);
        chk("R7 stall empty", {31'd0, stall}, 32'd1);
        chk("R7 no write", {31'd0, rd_we}, 32'd0);
        issue(1'b1, I_WAIT, 32'h0, 32'h54, 32'h0000_0080);
        chk("R7 stall before latch", {31'd0, stall}, 32'd1);
        issue(1'b1, I_WAIT, 32'h0, 32'h54, 32'h0);
        chk("R7 stall released", {31'd0, stall}, 32'd0);
        chk("R7 pending value", rd_val, 32'h0000_0080);
        chk("R7 write", {31'd0, rd_we}, 32'd1);
        chk("R10 masked no entry", {31'd0, irq_enter}, 32'd0);
    endtask

    task automatic t_single_entry();
        issue(1'b0, 32'h13, 32'h0, 32'h0, 32'h0000_0020);
        idle();
        chk("R10 masked bit5 no entry", {31'd0, irq_enter}, 32'd0);
        issue(1'b1, I_WAIT, 32'h0, 32'h60, 32'h0);
        chk("R10 both pending", rd_val, 32'h0000_00A0);
        issue(1'b1, I_MASK, ~32'h20, 32'h64, 32'h0);
        chk("R3 old mask", rd_val, 32'hFFFF_FFFF);
        issue(1'b0, 32'h13, 32'h0, 32'h100, 32'h0);
        chk("R4 enter", {31'd0, irq_enter}, 32'd1);
        chk("R4 target", pc_target, 32'h0000_0010);
        idle();
        chk("R4 no reentry", {31'd0, irq_enter}, 32'd0);
        issue(1'b1, i_getq(2'd0), 32'h0, 32'h10, 32'h0);
        chk("R4 q0 return", rd_val, 32'h0000_0100);
        issue(1'b1, i_getq(2'd1), 32'h0, 32'h14, 32'h0);
        chk("R4 q1 bits", rd_val, 32'h0000_0020);
        issue(1'b1, I_WAIT, 32'h0, 32'h18, 32'h0);
        chk("R4 serviced cleared", rd_val, 32'h0000_0080);
        issue(1'b1, I_RET, 32'h0, 32'h1C, 32'h0);
        chk("R6 redirect", {31'd0, pc_redir}, 32'd1);
        chk("R6 target", pc_target, 32'h0000_0100);
        idle();
        chk("R6 no entry after ret", {31'd0, irq_enter}, 32'd0);
    endtask

    task automatic t_multi_entry();
        issue(1'b1, I_MASK, ~32'h318, 32'h104, 32'h0);
        chk("R3 swap returns prior", rd_val, ~32'h20);
        issue(1'b0, 32'h13, 32'h0, 32'h0, 32'h0000_1108);
        chk("R4 not yet latched", {31'd0, irq_enter}, 32'd0);
        issue(1'b1, i_getq(2'd2), 32'h0, 32'h200, 32'h0);
        chk("R12 enter wins", {31'd0, irq_enter}, 32'd1);
        chk("R12 no write", {31'd0, rd_we}, 32'd0);
        issue(1'b1, i_getq(2'd1), 32'h0, 32'h10, 32'h0);
        chk("R5 combined bits", rd_val, 32'h0000_0108);
        issue(1'b1, i_getq(2'd0), 32'h0, 32'h14, 32'h0);
        chk("R12 q0 is preempted pc", rd_val, 32'h0000_0200);
        issue(1'b1, I_WAIT, 32'h0, 32'h18, 32'h0);
        chk("R10 masked left pending", rd_val, 32'h0000_1080);
        issue(1'b1, I_RET, 32'h0, 32'h1C, 32'h0);
        chk("R6 target second", pc_target, 32'h0000_0200);
        idle();
        chk("R10 still masked", {31'd0, irq_enter}, 32'd0);
    endtask

    task automatic t_illegal();
        issue(1'b1, enc(7'd3, 5'd6, 3'd1, 5'd5, 7'b0001011), 32'h0, 32'h300, 32'h0);
        chk("R8 bad funct3 flag", {31'd0, illegal}, 32'd1);
        chk("R8 bad funct3 no write", {31'd0, rd_we}, 32'd0);
        issue(1'b1, enc(7'd5, 5'd0, 3'd0, 5'd5, 7'b0001011), 32'h0, 32'h304, 32'h0);
        chk("R8 bad funct7 flag", {31'd0, illegal}, 32'd1);
        issue(1'b1, {7'd3, 5'd1, 5'd6, 3'd0, 5'd5, 7'b0001011}, 32'h0, 32'h308, 32'h0);
        chk("R8 bad rs2 flag", {31'd0, illegal}, 32'd1);
        issue(1'b1, I_MASK, ~32'h318, 32'h30C, 32'h0);
        chk("R8 mask unchanged", rd_val, ~32'h318);
        chk("R8 flag clear on legal", {31'd0, illegal}, 32'd0);
        issue(1'b1, enc(7'd0, 5'd1, 3'd0, 5'd5, 7'b0110011), 32'h0, 32'h310, 32'h0);
        chk("R11 other opcode no write", {31'd0, rd_we}, 32'd0);
        chk("R11 other opcode no flag", {31'd0, illegal}, 32'd0);
        chk("R11 other opcode no redirect", {31'd0, pc_redir}, 32'd0);
    endtask

    task automatic t_trap();
        issue(1'b0, 32'h13, 32'h0, 32'h0, 32'h0000_0001);
        chk("R9 not halted before edge", {31'd0, halted}, 32'd0);
        idle();
        chk("R9 halted", {31'd0, halted}, 32'd1);
        chk("R9 stall", {31'd0, stall}, 32'd1);
        issue(1'b1, i_getq(2'd2), 32'h0, 32'h400, 32'h0);
        chk("R9 no write", {31'd0, rd_we}, 32'd0);
        idle();
        chk("R9 sticky", {31'd0, halted}, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_shadow();
        t_wait();
        t_single_entry();
        t_multi_entry();
        t_illegal();
        t_trap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule